// File: doc/BRIEF.md
# Serial Port Data Register Front End

This block sits between a byte-wide CPU bus and the separate receive and transmit shift engines of an asynchronous serial port. One bus address reaches two registers: a bus read returns the receive buffer, and a bus write loads the transmit buffer. The two are fully separate. A read never returns the last value written.

On the receive side, the receive engine delivers a byte with a valid strobe, together with parity and framing error strobes. The block holds the byte and raises a receive-full flag. A bus read clears that flag. A byte with an error is marked invalid, and so is a buffer that suffered an overrun. While the buffer is invalid it reads as zero. On the transmit side, a bus write made while transmission is enabled fills the transmit buffer and clears the transmit-empty flag. The block then offers the byte to the shift engine with a request/acknowledge handshake.

Both interrupt requests are level signals. Each one is a flag gated by its enable. A reduced-width mode clears the top data bit in both directions.

Top module: `serDataRegs`

## Requirements
- R1: After reset, rxFull=0, rxErr=0, txEmpty=1, txReq=0, rxIrq=0, txIrq=0 and ovrPulse=0.
- R2: A cycle with rxByteValid=1 while rxFull=0 stores rxByte, and rxFull reads 1 after that clock edge. With sevenBit=0, a following bus read (busSel=1, busWr=0) returns the byte unchanged on busRdata in the same cycle.
- R3: rxIrq equals rxFull AND rxIntEn at all times.
- R4: A bus read clears rxFull to 0 at the next edge. A bus write does not change rxFull or the receive buffer, so a read after a write returns the received byte and not the written one.
- R5: A byte delivered with rxParityErr=1 or rxFrameErr=1 still sets rxFull. It also sets rxErr to 1. While rxErr=1, busRdata reads 8'h00. A bus read clears rxErr.
- R6: A byte that arrives while rxFull=1, in a cycle with no bus read, is discarded. ovrPulse is 1 for exactly the following cycle, and rxErr becomes 1.
- R7: With sevenBit=1, bit 7 of a received byte is stored as 0, and bit 7 of a written transmit byte is stored as 0.
- R8: A bus write (busSel=1, busWr=1) while txEnable=1 stores busWdata. After the edge, txEmpty=0, txReq=1 and txByte holds the stored value.
- R9: txAck=1 while txReq=1 sets txEmpty to 1 and drops txReq at the next edge, unless a new write arrives in the same cycle.
- R10: txIrq equals txEmpty AND txIntEn at all times.
- R11: A bus write while txEnable=0 is ignored. txEmpty and txByte keep their values.
- R12: A bus write while txEmpty=0 (and txEnable=1) replaces the pending byte on txByte. txEmpty stays 0.
- R13: A bus read and a byte arrival in the same cycle keep the new byte with rxFull=1 and produce no overrun pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access to the shared data address this cycle |
| busWr | input | 1 | 1 = write (transmit buffer), 0 = read (receive buffer) |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data from the receive buffer, zero while invalid |
| sevenBit | input | 1 | Reduced-width mode, top data bit forced to 0 |
| txEnable | input | 1 | Transmission enabled |
| rxIntEn | input | 1 | Receive interrupt enable |
| txIntEn | input | 1 | Transmit interrupt enable |
| rxByteValid | input | 1 | Receive engine delivers a complete byte |
| rxByte | input | 8 | Received byte |
| rxParityErr | input | 1 | Parity error for the delivered byte |
| rxFrameErr | input | 1 | Framing error for the delivered byte |
| txAck | input | 1 | Transmit engine takes the offered byte |
| txReq | output | 1 | A transmit byte is waiting |
| txByte | output | 8 | Byte offered to the transmit engine |
| rxFull | output | 1 | Receive-full flag |
| rxErr | output | 1 | Buffered receive data is invalid |
| txEmpty | output | 1 | Transmit-empty flag |
| rxIrq | output | 1 | Receive interrupt request |
| txIrq | output | 1 | Transmit interrupt request |
| ovrPulse | output | 1 | One-cycle overrun strobe |

## Verification
A wrong flag shows at the ports one cycle after the stimulus that caused it, either on the flag itself or on its interrupt request. A receive-full flag that is stuck or fails to clear shows on the next read or the next arrival. It appears as a missing or a spurious overrun pulse. Faults in the buffer registers, such as a wrong mask or a missed load, show on busRdata during the next read, or on txByte right after the write that should have set it. Corrupted invalid marking shows as a nonzero read after an error.

// File: rtl/serRegsPkg.sv
package serRegsPkg;
  typedef struct packed {
    logic loadRx;
    logic clearRx;
    logic loadTx;
    logic releaseTx;
  } ctlStrobes_t;
endpackage

// File: rtl/serRegsCtrl.sv
module serRegsCtrl
  import serRegsPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic        txEnable,
  input  logic        rxIntEn,
  input  logic        txIntEn,
  input  logic        rxByteValid,
  input  logic        rxParityErr,
  input  logic        rxFrameErr,
  input  logic        txAck,
  output ctlStrobes_t strb,
  output logic        rxFull,
  output logic        rxErr,
  output logic        txEmpty,
  output logic        rxIrq,
  output logic        txIrq,
  output logic        ovrPulse
);
  logic rdStb;
  logic wrStb;
  logic overrun;

  assign rdStb   = busSel & ~busWr;
  assign wrStb   = busSel & busWr & txEnable;
  // a read in the same cycle frees the buffer, so arrival is not an overrun
  assign overrun = rxByteValid & rxFull & ~rdStb;

  always_comb begin
    strb           = '0;
    strb.loadRx    = rxByteValid & ~overrun;
    strb.clearRx   = rdStb;
    strb.loadTx    = wrStb;
    strb.releaseTx = txAck & ~txEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxFull   <= 1'b0;
      rxErr    <= 1'b0;
      txEmpty  <= 1'b1;
      ovrPulse <= 1'b0;
    end else begin
      ovrPulse <= overrun;
      if (strb.loadRx) begin
        rxFull <= 1'b1;
        rxErr  <= rxParityErr | rxFrameErr;
      end else if (overrun) begin
        rxErr  <= 1'b1;
      end else if (strb.clearRx) begin
        rxFull <= 1'b0;
        rxErr  <= 1'b0;
      end
      if (strb.loadTx)         txEmpty <= 1'b0;
      else if (strb.releaseTx) txEmpty <= 1'b1;
    end
  end

  assign rxIrq = rxFull & rxIntEn;
  assign txIrq = txEmpty & txIntEn;

  AST_RX_SET: assert property (@(posedge clk) disable iff (!rstN)
    (rxByteValid && !rxFull) |=> rxFull); // R2
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && !rxByteValid) |=> !rxFull); // R4
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrPulse) |-> ($past(rxFull) && $past(rxByteValid))); // R6
  AST_OVR_MARKS: assert property (@(posedge clk) disable iff (!rstN)
    ovrPulse |-> rxErr); // R6
  AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && txEnable) |=> !txEmpty); // R8
  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (txAck && !txEmpty && !(busSel && busWr && txEnable)) |=> txEmpty); // R9
  AST_TX_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && !txEnable && !txAck) |=> $stable(txEmpty)); // R11
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && rxByteValid) |=> (rxFull && !ovrPulse)); // R13
endmodule

// File: rtl/serRegsData.sv
module serRegsData
  import serRegsPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic              sevenBit,
  input  logic              rxErr,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] txByte
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] rxBuf;
  logic [DATA_W-1:0] txBuf;
  logic [DATA_W-1:0] topMask;

  // in reduced mode the top bit carries nothing and is stored as zero
  always_comb begin
    topMask      = '1;
    topMask[MSB] = ~sevenBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBuf <= '0;
      txBuf <= '0;
    end else begin
      if (strb.loadRx) rxBuf <= rxByte & topMask;
      if (strb.loadTx) txBuf <= busWdata & topMask;
    end
  end

  assign busRdata = rxErr ? '0 : rxBuf;
  assign txByte   = txBuf;

  AST_TX_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadTx && sevenBit) |=> !txBuf[MSB]); // R7
  AST_RX_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadRx && sevenBit) |=> !rxBuf[MSB]); // R7
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadTx |=> $stable(txByte)); // R11
endmodule

// File: rtl/serDataRegs.sv
module serDataRegs
  import serRegsPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              sevenBit,
  input  logic              txEnable,
  input  logic              rxIntEn,
  input  logic              txIntEn,
  input  logic              rxByteValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxParityErr,
  input  logic              rxFrameErr,
  input  logic              txAck,
  output logic              txReq,
  output logic [DATA_W-1:0] txByte,
  output logic              rxFull,
  output logic              rxErr,
  output logic              txEmpty,
  output logic              rxIrq,
  output logic              txIrq,
  output logic              ovrPulse
);
  ctlStrobes_t strb;

  serRegsCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .txEnable(txEnable), .rxIntEn(rxIntEn), .txIntEn(txIntEn),
    .rxByteValid(rxByteValid), .rxParityErr(rxParityErr),
    .rxFrameErr(rxFrameErr), .txAck(txAck), .strb(strb),
    .rxFull(rxFull), .rxErr(rxErr), .txEmpty(txEmpty),
    .rxIrq(rxIrq), .txIrq(txIrq), .ovrPulse(ovrPulse)
  );

  serRegsData #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .sevenBit(sevenBit),
    .rxErr(rxErr), .rxByte(rxByte), .busWdata(busWdata),
    .busRdata(busRdata), .txByte(txByte)
  );

  assign txReq = ~txEmpty;
endmodule

// File: tb/test_serDataRegs.sv
module test_serDataRegs;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       sevenBit = 1'b0, txEnable = 1'b1, rxIntEn = 1'b0, txIntEn = 1'b0;
  logic       rxByteValid = 1'b0, rxParityErr = 1'b0, rxFrameErr = 1'b0;
  logic [7:0] rxByte = '0;
  logic       txAck = 1'b0;
  logic       txReq, rxFull, rxErr, txEmpty, rxIrq, txIrq, ovrPulse;
  logic [7:0] txByte;
  int checks = 0, errors = 0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  serDataRegs i_serDataRegs (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .sevenBit(sevenBit),
    .txEnable(txEnable), .rxIntEn(rxIntEn), .txIntEn(txIntEn),
    .rxByteValid(rxByteValid), .rxByte(rxByte), .rxParityErr(rxParityErr),
    .rxFrameErr(rxFrameErr), .txAck(txAck), .txReq(txReq), .txByte(txByte),
    .rxFull(rxFull), .rxErr(rxErr), .txEmpty(txEmpty), .rxIrq(rxIrq),
    .txIrq(txIrq), .ovrPulse(ovrPulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // deliver one byte, then check at the next falling edge
  task automatic deliver(input logic [7:0] b, input logic pe, input logic fe);
    @(negedge clk);
    rxByteValid = 1'b1; rxByte = b; rxParityErr = pe; rxFrameErr = fe;
    @(negedge clk);
    rxByteValid = 1'b0; rxParityErr = 1'b0; rxFrameErr = 1'b0;
  endtask

  task automatic busRead(output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic busWrite(input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic tReset;
    chk("R1 rxFull", rxFull, 0);
    chk("R1 rxErr", rxErr, 0);
    chk("R1 txEmpty", txEmpty, 1);
    chk("R1 txReq", txReq, 0);
    chk("R1 irqs", {rxIrq, txIrq}, 0);
    chk("R1 ovrPulse", ovrPulse, 0);
  endtask

  task automatic tReceive;
    rxIntEn = 1'b0;
    deliver(8'hA5, 0, 0);
    chk("R2 rxFull set", rxFull, 1);
    chk("R3 rxIrq gated off", rxIrq, 0);
    rxIntEn = 1'b1; #1;
    chk("R3 rxIrq on", rxIrq, 1);
    busWrite(8'h3C);
    chk("R4 write keeps rxFull", rxFull, 1);
    busRead(rd);
    chk("R2 R4 read data not written value", rd, 8'hA5);
    chk("R4 read clears rxFull", rxFull, 0);
    chk("R3 rxIrq drops", rxIrq, 0);
    rxIntEn = 1'b0;
    // drain the transmit byte left by the write
    @(negedge clk); txAck = 1'b1; @(negedge clk); txAck = 1'b0;
  endtask

  task automatic tErrors;
    deliver(8'h77, 1, 0);
    chk("R5 parity sets rxFull", rxFull, 1);
    chk("R5 parity sets rxErr", rxErr, 1);
    busRead(rd);
    chk("R5 invalid reads zero", rd, 0);
    chk("R5 read clears rxErr", rxErr, 0);
    deliver(8'h42, 0, 1);
    chk("R5 framing sets rxErr", rxErr, 1);
    busRead(rd);
    deliver(8'h11, 0, 0);
    chk("R5 clean byte rxErr", rxErr, 0);
    busRead(rd);
    chk("R5 clean byte data", rd, 8'h11);
  endtask

  task automatic tOverrun;
    deliver(8'h12, 0, 0);
    @(negedge clk);
    rxByteValid = 1'b1; rxByte = 8'h34;
    @(negedge clk);
    rxByteValid = 1'b0;
    chk("R6 ovrPulse high", ovrPulse, 1);
    chk("R6 rxErr set", rxErr, 1);
    @(negedge clk);
    chk("R6 ovrPulse one cycle", ovrPulse, 0);
    busRead(rd);
    chk("R6 overrun reads zero", rd, 0);
  endtask

  task automatic tSameCycle;
    deliver(8'h21, 0, 0);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; rxByteValid = 1'b1; rxByte = 8'h65;
    #1 rd = busRdata;
    @(negedge clk);
    busSel = 1'b0; rxByteValid = 1'b0;
    chk("R13 old byte read", rd, 8'h21);
    chk("R13 rxFull stays", rxFull, 1);
    chk("R13 no overrun", ovrPulse, 0);
    busRead(rd);
    chk("R13 new byte kept", rd, 8'h65);
  endtask

  task automatic tSeven;
    sevenBit = 1'b1;
    deliver(8'hFF, 0, 0);
    busRead(rd);
    chk("R7 rx top bit cleared", rd, 8'h7F);
    busWrite(8'h9C);
    chk("R7 tx top bit cleared", txByte, 8'h1C);
    @(negedge clk); txAck = 1'b1; @(negedge clk); txAck = 1'b0;
    sevenBit = 1'b0;
  endtask

  task automatic tTransmit;
    txIntEn = 1'b1; #1;
    chk("R10 txIrq when empty", txIrq, 1);
    busWrite(8'hC3);
    chk("R8 txEmpty cleared", txEmpty, 0);
    chk("R8 txReq", txReq, 1);
    chk("R8 txByte", txByte, 8'hC3);
    chk("R10 txIrq drops", txIrq, 0);
    busWrite(8'h5A);
    chk("R12 overwrite byte", txByte, 8'h5A);
    chk("R12 still not empty", txEmpty, 0);
    @(negedge clk); txAck = 1'b1; @(negedge clk); txAck = 1'b0;
    chk("R9 ack sets empty", txEmpty, 1);
    chk("R9 txReq drops", txReq, 0);
    chk("R10 txIrq back", txIrq, 1);
    txIntEn = 1'b0; #1;
    chk("R10 txIrq gated", txIrq, 0);
    txEnable = 1'b0;
    busWrite(8'hE1);
    chk("R11 disabled write empty", txEmpty, 1);
    chk("R11 disabled write byte", txByte, 8'h5A);
    txEnable = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tReceive();
    tErrors();
    tOverrun();
    tSameCycle();
    tSeven();
    tTransmit();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule